// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block steps a chip into and out of one of three suspend depths. It drives four request pins: a CPU rail request, a core rail request, a system-clock (oscillator) request and a DRAM self-refresh request. An external regulator and a memory controller act on these pins. All timed waits count pulses of a 32.768 kHz always-on tick, which arrives as a one-cycle strobe in the fast clock domain. Each wait is set in microseconds and converted to ticks inside the block.

Software picks the depth, the five durations, the active level of the core and clock pins, a merged-request option and an optional power-good handshake, all through static configuration inputs. A one-cycle sleep pulse starts the descent. A one-cycle wake pulse starts the climb back. When the climb finishes, a one-cycle resume-complete strobe is raised.

Top module: `sleep_seq`

## Requirements
- R1: After reset the logical rail state is CPU on, core on, clock on, self-refresh off and resume strobe low. The pins show this through the polarity rules of R9 and R10.
- R2: Depth code 0 descends in two steps. First the CPU request drops and self-refresh asserts, and this lasts for the CPU-off wait. Then the core request and the clock request drop, and this lasts for the core-off wait before the block counts as asleep.
- R3: Depth code 1 drops only the CPU request and asserts self-refresh. The core and clock requests stay up for the whole cycle.
- R4: Depth code 2 drops only the CPU request and never asserts self-refresh. Depth code 3 behaves exactly like code 2.
- R5: A duration of U microseconds lasts ceil(U*32768/1000000) tick pulses. A setting of 0 gives no wait.
- R6: When a depth-0 cycle exits, the clock request rises first and is held for the oscillator wait. The core request then rises and is held for the power-stable wait. Only after that does the CPU request rise.
- R7: After the CPU request rises, the block waits for the CPU power-good duration. When the handshake is enabled, it then also waits for the power-good input to be high. No resume strobe appears while that input is low.
- R8: Resume is marked by a one-cycle strobe. Self-refresh is released in the same cycle. The block then returns to the awake state.
- R9: The core and clock pins each carry their logical request unchanged when their active-high setting is 1, and inverted when it is 0. The CPU and self-refresh pins are always active high.
- R10: With the merged option set, the core pin carries (CPU on AND core on) at its configured polarity, and the CPU pin is held at 0.
- R11: A wake pulse during the descent is remembered and starts the climb as soon as the block is asleep. A wake pulse while awake has no effect. A sleep pulse while not awake has no effect.
- R12: The depth is captured when the sleep pulse is taken. A change to the depth input during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle strobe per 32.768 kHz period |
| sleepReq | input | 1 | Sleep command pulse |
| wakeIn | input | 1 | Wake event pulse |
| cpuPwrGood | input | 1 | CPU rail good from the regulator |
| cfgMode | input | 2 | Suspend depth code 0..3 |
| cfgCpuOffUs | input | US_W | CPU off wait, microseconds |
| cfgCpuGoodUs | input | US_W | CPU power-good wait, microseconds |
| cfgCoreOffUs | input | US_W | Core off wait, microseconds |
| cfgOscUs | input | US_W | Oscillator stable wait, microseconds |
| cfgPwrUs | input | US_W | Core power stable wait, microseconds |
| cfgCoreActHigh | input | 1 | Core pin active level (1 = high) |
| cfgClkActHigh | input | 1 | Clock pin active level (1 = high) |
| cfgCombined | input | 1 | Merge CPU and core requests on the core pin |
| cfgPgEnable | input | 1 | Require cpuPwrGood before resume |
| cpuPwrReq | output | 1 | CPU rail request |
| corePwrReq | output | 1 | Core rail (or merged) request |
| sysClkReq | output | 1 | System clock request |
| dramSrReq | output | 1 | DRAM self-refresh request |
| resumeDone | output | 1 | One-cycle resume complete strobe |

## Verification
The bench builds the block with its default 16-bit microsecond fields and the 32768 Hz timebase, and it strobes a tick every eighth fast cycle. With this setup, short settings such as 30, 62, 100 and 200 us give waits of 1, 3, 4 and 7 ticks, which keeps each cycle brief. The 16-bit width also admits 15625 us, which converts to exactly 512 ticks, and 15626 us, which rounds up to 513, so both sides of the rounding boundary fall within one run. A zero setting exercises the no-wait path. The monitor counts ticks between pin changes, so every interval is checked to the tick.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [3:0] {
    ST_ACTIVE, ST_CPU_OFF, ST_CORE_OFF, ST_ASLEEP,
    ST_OSC, ST_PWR, ST_CPU_ON, ST_PG_WAIT, ST_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    DLY_CPU_OFF, DLY_CORE_OFF, DLY_OSC, DLY_PWR, DLY_CPU_GOOD
  } dlySel_e;

  // logical (polarity-free) request levels
  typedef struct packed {
    logic cpuOn;
    logic coreOn;
    logic clkOn;
    logic srOn;
    logic done;
  } railReq_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     load;
    dlySel_e  sel;
    railReq_t rails;
  } seqStrobe_t;

endpackage

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       wakeIn,
  input  logic       cpuPwrGood,
  input  logic [1:0] cfgMode,
  input  logic       cfgPgEnable,
  input  logic       dlyDone,
  output seqStrobe_t strb
);

  seqState_e state, nextState;
  logic [1:0] modeQ;
  logic       wakePend;
  logic       wakeGo;

  assign wakeGo = wakePend | wakeIn;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_ACTIVE:   if (sleepReq) nextState = ST_CPU_OFF;
      ST_CPU_OFF:  if (dlyDone) nextState = (modeQ == 2'd0) ? ST_CORE_OFF : ST_ASLEEP;
      ST_CORE_OFF: if (dlyDone) nextState = ST_ASLEEP;
      ST_ASLEEP:   if (wakeGo) nextState = (modeQ == 2'd0) ? ST_OSC : ST_CPU_ON;
      ST_OSC:      if (dlyDone) nextState = ST_PWR;
      ST_PWR:      if (dlyDone) nextState = ST_CPU_ON;
      ST_CPU_ON:   if (dlyDone) nextState = cfgPgEnable ? ST_PG_WAIT : ST_DONE;
      ST_PG_WAIT:  if (cpuPwrGood) nextState = ST_DONE;
      ST_DONE:     nextState = ST_ACTIVE;
      default:     nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_ACTIVE;
      modeQ    <= 2'd0;
      wakePend <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_ACTIVE && sleepReq)
        modeQ <= (cfgMode == 2'd3) ? 2'd2 : cfgMode;
      if (state == ST_ASLEEP && wakeGo)
        wakePend <= 1'b0;
      else if (wakeIn && (state == ST_CPU_OFF || state == ST_CORE_OFF))
        wakePend <= 1'b1;
    end
  end

  // delay load strobe on entry into a timed state
  always_comb begin
    strb.load = 1'b0;
    strb.sel  = DLY_CPU_OFF;
    if (nextState != state) begin
      unique case (nextState)
        ST_CPU_OFF:  begin strb.load = 1'b1; strb.sel = DLY_CPU_OFF;  end
        ST_CORE_OFF: begin strb.load = 1'b1; strb.sel = DLY_CORE_OFF; end
        ST_OSC:      begin strb.load = 1'b1; strb.sel = DLY_OSC;      end
        ST_PWR:      begin strb.load = 1'b1; strb.sel = DLY_PWR;      end
        ST_CPU_ON:   begin strb.load = 1'b1; strb.sel = DLY_CPU_GOOD; end
        default:     ;
      endcase
    end
  end

  // logical rail levels per state
  always_comb begin
    strb.rails = '{cpuOn: 1'b1, coreOn: 1'b1, clkOn: 1'b1, srOn: 1'b0, done: 1'b0};
    unique case (state)
      ST_CPU_OFF: begin
        strb.rails.cpuOn = 1'b0;
        strb.rails.srOn  = (modeQ != 2'd2);
      end
      ST_CORE_OFF: strb.rails = '{cpuOn: 1'b0, coreOn: 1'b0, clkOn: 1'b0, srOn: 1'b1, done: 1'b0};
      ST_ASLEEP: begin
        strb.rails.cpuOn  = 1'b0;
        strb.rails.coreOn = (modeQ != 2'd0);
        strb.rails.clkOn  = (modeQ != 2'd0);
        strb.rails.srOn   = (modeQ != 2'd2);
      end
      ST_OSC: strb.rails = '{cpuOn: 1'b0, coreOn: 1'b0, clkOn: 1'b1, srOn: 1'b1, done: 1'b0};
      ST_PWR: strb.rails = '{cpuOn: 1'b0, coreOn: 1'b1, clkOn: 1'b1, srOn: 1'b1, done: 1'b0};
      ST_CPU_ON, ST_PG_WAIT: strb.rails.srOn = (modeQ != 2'd2);
      ST_DONE: strb.rails.done = 1'b1;
      default: ;
    endcase
  end

  // R2: core rail may only drop in a depth-0 cycle
  a_r2_core_off_mode0: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rails.coreOn |-> modeQ == 2'd0);
  // R4: depth 2 (and 3) never requests self-refresh
  a_r4_no_sr_mode2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rails.srOn && modeQ == 2'd2));
  // R11: a remembered wake leaves sleep on the next edge
  a_r11_wake_kept: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASLEEP && wakePend) |=> (state == ST_OSC || state == ST_CPU_ON));
  // R7: power-good low holds the sequence
  a_r7_pg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PG_WAIT && !cpuPwrGood) |=> state == ST_PG_WAIT);
  // R8: resume strobe lasts one cycle then back to awake
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.rails.done |=> (state == ST_ACTIVE && !strb.rails.done));

endmodule

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int US_W  = 16,
  parameter int TB_HZ = 32768,
  parameter int MICRO = 1000000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slowTick,
  input  seqStrobe_t      strb,
  input  logic [US_W-1:0] cfgCpuOffUs,
  input  logic [US_W-1:0] cfgCpuGoodUs,
  input  logic [US_W-1:0] cfgCoreOffUs,
  input  logic [US_W-1:0] cfgOscUs,
  input  logic [US_W-1:0] cfgPwrUs,
  input  logic            cfgCoreActHigh,
  input  logic            cfgClkActHigh,
  input  logic            cfgCombined,
  output logic            dlyDone,
  output logic            cpuPwrReq,
  output logic            corePwrReq,
  output logic            sysClkReq,
  output logic            dramSrReq,
  output logic            resumeDone
);

  // tick rate is below one per microsecond, so ticks never exceed the us value
  localparam int TICK_W = US_W;
  localparam int PROD_W = US_W + $clog2(TB_HZ + 1) + 1;

  logic [US_W-1:0]   usSel;
  logic [PROD_W-1:0] prodRnd;
  logic [PROD_W-1:0] ticksWide;
  logic [TICK_W-1:0] ticks;
  logic [TICK_W-1:0] cnt;
  logic              coreLvl;

  always_comb begin
    unique case (strb.sel)
      DLY_CPU_OFF:  usSel = cfgCpuOffUs;
      DLY_CORE_OFF: usSel = cfgCoreOffUs;
      DLY_OSC:      usSel = cfgOscUs;
      DLY_PWR:      usSel = cfgPwrUs;
      default:      usSel = cfgCpuGoodUs;
    endcase
  end

  // ceil(us * TB_HZ / MICRO)
  assign prodRnd   = PROD_W'(usSel) * PROD_W'(TB_HZ) + PROD_W'(MICRO - 1);
  assign ticksWide = prodRnd / PROD_W'(MICRO);
  assign ticks     = TICK_W'(ticksWide);

  always_ff @(posedge clk) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.load)               cnt <= ticks;
    else if (slowTick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign dlyDone = (cnt == '0);

  assign coreLvl    = cfgCombined ? (strb.rails.cpuOn & strb.rails.coreOn) : strb.rails.coreOn;
  assign cpuPwrReq  = cfgCombined ? 1'b0 : strb.rails.cpuOn;
  assign corePwrReq = coreLvl ~^ cfgCoreActHigh;
  assign sysClkReq  = strb.rails.clkOn ~^ cfgClkActHigh;
  assign dramSrReq  = strb.rails.srOn;
  assign resumeDone = strb.rails.done;

  // R5: an expired counter stays at zero until reloaded
  a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strb.load) |=> cnt == '0);
  // R5: each tick removes exactly one count
  a_r5_tick_step: assert property (@(posedge clk) disable iff (!rstN)
    (slowTick && cnt != '0 && !strb.load) |=> cnt == TICK_W'($past(cnt) - 1'b1));

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int US_W  = 16,
  parameter int TB_HZ = 32768,
  parameter int MICRO = 1000000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slowTick,
  input  logic            sleepReq,
  input  logic            wakeIn,
  input  logic            cpuPwrGood,
  input  logic [1:0]      cfgMode,
  input  logic [US_W-1:0] cfgCpuOffUs,
  input  logic [US_W-1:0] cfgCpuGoodUs,
  input  logic [US_W-1:0] cfgCoreOffUs,
  input  logic [US_W-1:0] cfgOscUs,
  input  logic [US_W-1:0] cfgPwrUs,
  input  logic            cfgCoreActHigh,
  input  logic            cfgClkActHigh,
  input  logic            cfgCombined,
  input  logic            cfgPgEnable,
  output logic            cpuPwrReq,
  output logic            corePwrReq,
  output logic            sysClkReq,
  output logic            dramSrReq,
  output logic            resumeDone
);

  seqStrobe_t strb;
  logic       dlyDone;

  sleep_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .wakeIn     (wakeIn),
    .cpuPwrGood (cpuPwrGood),
    .cfgMode    (cfgMode),
    .cfgPgEnable(cfgPgEnable),
    .dlyDone    (dlyDone),
    .strb       (strb)
  );

  sleep_seq_dp #(.US_W(US_W), .TB_HZ(TB_HZ), .MICRO(MICRO)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .slowTick      (slowTick),
    .strb          (strb),
    .cfgCpuOffUs   (cfgCpuOffUs),
    .cfgCpuGoodUs  (cfgCpuGoodUs),
    .cfgCoreOffUs  (cfgCoreOffUs),
    .cfgOscUs      (cfgOscUs),
    .cfgPwrUs      (cfgPwrUs),
    .cfgCoreActHigh(cfgCoreActHigh),
    .cfgClkActHigh (cfgClkActHigh),
    .cfgCombined   (cfgCombined),
    .dlyDone       (dlyDone),
    .cpuPwrReq     (cpuPwrReq),
    .corePwrReq    (corePwrReq),
    .sysClkReq     (sysClkReq),
    .dramSrReq     (dramSrReq),
    .resumeDone    (resumeDone)
  );

endmodule

// File: tb/tb_sleep_seq.sv
`timescale 1ns/1ps
module tb_sleep_seq;

  localparam int US_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, slowTick = 1'b0, sleepReq = 1'b0, wakeIn = 1'b0, cpuPwrGood = 1'b1;
  logic [1:0] cfgMode = 2'd0;
  logic [US_W-1:0] cfgCpuOffUs = 16'd100, cfgCpuGoodUs = 16'd200, cfgCoreOffUs = 16'd30;
  logic [US_W-1:0] cfgOscUs = 16'd62, cfgPwrUs = 16'd0;
  logic cfgCoreActHigh = 1'b1, cfgClkActHigh = 1'b1, cfgCombined = 1'b0, cfgPgEnable = 1'b0;
  logic cpuPwrReq, corePwrReq, sysClkReq, dramSrReq, resumeDone;

  sleep_seq #(.US_W(US_W)) dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .sleepReq(sleepReq), .wakeIn(wakeIn),
    .cpuPwrGood(cpuPwrGood), .cfgMode(cfgMode), .cfgCpuOffUs(cfgCpuOffUs),
    .cfgCpuGoodUs(cfgCpuGoodUs), .cfgCoreOffUs(cfgCoreOffUs), .cfgOscUs(cfgOscUs),
    .cfgPwrUs(cfgPwrUs), .cfgCoreActHigh(cfgCoreActHigh), .cfgClkActHigh(cfgClkActHigh),
    .cfgCombined(cfgCombined), .cfgPgEnable(cfgPgEnable), .cpuPwrReq(cpuPwrReq),
    .corePwrReq(corePwrReq), .sysClkReq(sysClkReq), .dramSrReq(dramSrReq),
    .resumeDone(resumeDone)
  );

  typedef struct {
    logic [4:0] vec;
    int         ticks;
    string      req;
  } item_t;

  item_t      expQ[$];
  int         nCmp = 0, nBad = 0;
  logic [4:0] lastExp;
  int         pend = 0;
  bit         monOn = 1'b0;
  bit         reported = 1'b0;

  function automatic logic [4:0] curPins();
    return {cpuPwrReq, corePwrReq, sysClkReq, dramSrReq, resumeDone};
  endfunction

  // expected pins from logical levels (R9, R10)
  function automatic logic [4:0] pinsOf(bit cpu, bit core, bit ck, bit sr, bit done);
    logic lvl;
    lvl = cfgCombined ? (cpu & core) : core;
    return {cfgCombined ? 1'b0 : cpu, lvl ~^ cfgCoreActHigh, ck ~^ cfgClkActHigh, sr, done};
  endfunction

  // R5 rounding rule
  function automatic int ticksOf(logic [US_W-1:0] us);
    longint p;
    p = (longint'(us) * 32768 + 999999) / 1000000;
    return int'(p);
  endfunction

  task automatic step(logic [4:0] v, int t, string r);
    item_t it;
    if (v == lastExp) begin
      if (pend >= 0 && t >= 0) pend += t; else pend = -1;
    end else begin
      it.vec   = v;
      it.ticks = (pend >= 0 && t >= 0) ? pend + t : -1;
      it.req   = r;
      expQ.push_back(it);
      lastExp = v;
      pend    = 0;
    end
  endtask

  task automatic check(bit ok, string r, string what, int act, int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // tick generator: one pulse every 8 cycles, driven after the edge
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph = (ph + 1) % 8;
      slowTick = (ph == 0);
    end
  end

  // monitor: pops expected pin changes and checks tick spacing
  initial begin
    logic [4:0] prev, cur;
    int tickCnt;
    item_t it;
    tickCnt = 0;
    wait (monOn);
    @(negedge clk);
    prev = curPins();
    forever begin
      @(negedge clk);
      cur = curPins();
      if (cur != prev) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11", "unexpected pin change", int'(cur), int'(prev));
        end else begin
          it = expQ.pop_front();
          check(cur == it.vec, it.req, "pins", int'(cur), int'(it.vec));
          if (it.ticks >= 0)
            check(tickCnt == it.ticks, it.req, "tick interval", tickCnt, it.ticks);
        end
        prev    = cur;
        tickCnt = 0;
      end
      if (slowTick) tickCnt++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseSleep();
    @(posedge clk); #1 sleepReq = 1'b1;
    @(posedge clk); #1 sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    @(posedge clk); #1 wakeIn = 1'b1;
    @(posedge clk); #1 wakeIn = 1'b0;
  endtask

  task automatic drainTo(int n);
    while (expQ.size() > n) @(posedge clk);
    #1;
  endtask

  // push the whole expected cycle for normalized depth mm
  task automatic expectCycle(int mm, bit latched, bit pgSlow);
    int sleepT, first;
    string er;
    er = (mm == 0) ? "R2" : (mm == 1) ? "R3" : "R4";
    step(pinsOf(0, 1, 1, mm != 2, 0), -1, er);
    if (mm == 0) begin
      step(pinsOf(0, 0, 0, 1, 0), ticksOf(cfgCpuOffUs), "R2");
      sleepT = ticksOf(cfgCoreOffUs);
    end else sleepT = ticksOf(cfgCpuOffUs);
    first = latched ? sleepT : -1;
    if (mm == 0) begin
      step(pinsOf(0, 0, 1, 1, 0), first, "R6");
      step(pinsOf(0, 1, 1, 1, 0), ticksOf(cfgOscUs), "R6");
      step(pinsOf(1, 1, 1, 1, 0), ticksOf(cfgPwrUs), "R6");
    end else begin
      step(pinsOf(1, 1, 1, mm != 2, 0), first, "R7");
    end
    step(pinsOf(1, 1, 1, 0, 1), pgSlow ? -1 : ticksOf(cfgCpuGoodUs), "R7");
    step(pinsOf(1, 1, 1, 0, 0), pgSlow ? -1 : 0, "R8");
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1: reset state with active-high pins
    check(curPins() == 5'b11100, "R1", "reset pins", int'(curPins()), 5'b11100);
    lastExp = curPins();
    monOn = 1'b1;
    cyc(2);

    // depth 0, wake during descent is remembered (R2 R5 R6 R8 R11)
    cfgMode = 2'd0;
    expectCycle(0, 1'b1, 1'b0);
    pulseSleep();
    cyc(5);
    pulseWake();
    drainTo(0);
    cyc(20);
    check(expQ.size() == 0, "R8", "depth-0 cycle complete", expQ.size(), 0);

    // wake while awake is ignored (R11)
    pulseWake();
    cyc(30);
    check(curPins() == pinsOf(1, 1, 1, 0, 0), "R11", "wake while awake", int'(curPins()),
          int'(pinsOf(1, 1, 1, 0, 0)));

    // depth 1, depth changed mid-cycle (R12), second sleep ignored (R11), R3
    cfgMode = 2'd1;
    expectCycle(1, 1'b0, 1'b0);
    pulseSleep();
    cyc(3);
    cfgMode = 2'd0;
    pulseSleep();
    drainTo(3);
    cyc(40);
    check(expQ.size() == 3, "R11", "stays asleep without wake", expQ.size(), 3);
    check(curPins() == pinsOf(0, 1, 1, 1, 0), "R12", "captured depth 1 asleep",
          int'(curPins()), int'(pinsOf(0, 1, 1, 1, 0)));
    pulseWake();
    drainTo(0);
    cyc(10);

    // depth code 3 acts as 2, exact 512-tick boundary (R4 R5)
    cfgMode = 2'd3;
    cfgCpuOffUs = 16'd15625;
    expectCycle(2, 1'b1, 1'b0);
    pulseSleep();
    cyc(4);
    pulseWake();
    drainTo(0);
    cyc(10);

    // depth 2, 513-tick rounding, power-good handshake held low (R5 R7)
    cfgMode = 2'd2;
    cfgCpuOffUs = 16'd15626;
    cfgPgEnable = 1'b1;
    cpuPwrGood = 1'b0;
    expectCycle(2, 1'b1, 1'b1);
    pulseSleep();
    cyc(4);
    pulseWake();
    drainTo(2);
    cyc(100);
    check(expQ.size() == 2, "R7", "no resume while power-good low", expQ.size(), 2);
    check(resumeDone == 1'b0, "R7", "resume strobe low", int'(resumeDone), 0);
    cpuPwrGood = 1'b1;
    drainTo(0);
    cyc(10);
    cfgPgEnable = 1'b0;

    // inverted polarities and merged request, depth 0 (R9 R10)
    cfgCpuOffUs = 16'd100;
    cfgCoreActHigh = 1'b0;
    cfgClkActHigh = 1'b0;
    cfgCombined = 1'b1;
    step(pinsOf(1, 1, 1, 0, 0), -1, "R9");
    cyc(3);
    check(curPins() == 5'b00000, "R10", "merged low-active awake pins", int'(curPins()), 0);
    cfgMode = 2'd0;
    expectCycle(0, 1'b1, 1'b0);
    pulseSleep();
    cyc(5);
    pulseWake();
    drainTo(0);
    cyc(20);
    check(expQ.size() == 0, "R9", "polarity cycle complete", expQ.size(), 0);

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    report();
  end

endmodule